// File: doc/BRIEF.md
# Timer Interrupt Pending and Enable Controller

This block keeps the interrupt state of a timer that has four event sources, named A, B, C and D. The timer core sends one-cycle event strobes. Each strobe latches a pending flag for its source. Software uses a small register bus to program one enable bit per source. It can also raise pending flags itself and drop them again. The block drives one combined interrupt request to the CPU. What causes an event is decided in the timer core, not here.

Two registers sit on the bus. The control register holds the pending flags in its low nibble and the enable bits in its high nibble. Writing 0 to a pending bit in this register never clears it. The clear register is write-only and works as write-one-to-clear. Each source's pending flag is a two-state machine with the states `PEND_IDLE` and `PEND_SET`. It moves `PEND_IDLE -> PEND_SET` on an event or a software set. It moves `PEND_SET -> PEND_IDLE` on a clear write, but only when no event for that source arrives in the same cycle. In every other case it holds its state.

Top module: `tmr_irq_ctrl`

## Requirements
- R1: The control register is at address 0. Bit n (n = 0..3) is the pending flag of source n, where A=0, B=1, C=2 and D=3. Bit n+4 is the enable bit of the same source. The clear register is at address 1.
- R2: After reset, all pending flags and enable bits are 0, a read of address 0 returns 0x00, and the interrupt request is low.
- R3: An event strobe for a source sets that source's pending flag at the clock edge where the strobe is sampled.
- R4: A write to address 0 sets every pending flag whose data bit 3..0 is 1. Data bits that are 0 leave their pending flags unchanged.
- R5: A write to address 0 loads all four enable bits from data bits 7..4, whether each bit is 0 or 1.
- R6: A write to address 1 clears every pending flag whose data bit 3..0 is 1. Data bits that are 0 have no effect, and data bits 7..4 are ignored.
- R7: An event for a source whose enable bit is 0 still latches its pending flag but does not raise the interrupt request.
- R8: The interrupt request is a registered output. It equals, one cycle later, the OR over all sources of (pending AND enable).
- R9: If an event and a clear write for the same source fall in the same cycle, the pending flag ends up set.
- R10: A read of address 1 returns 0x00. A read of address 0 returns the current control value and changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 4 | One-cycle event strobes; bit n is for source n |
| bus_addr | input | 2 | Register address: 0 = control, 1 = clear |
| bus_we | input | 1 | Write enable for the current address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address (combinational) |
| irq_o | output | 1 | Registered interrupt request to the CPU |

## Verification
A pending flag stuck in the wrong state shows at once on a read of address 0. It shows on `irq_o` one clock after the flag meets a set enable bit. An enable bit loaded wrongly shows the same way: the read value is wrong immediately, and the request is wrong one cycle later. The bench keeps its own model of the flags, the enables and the request. It compares both outputs after every clock edge, so any difference is reported in the cycle it first appears. The event-versus-clear collision and writes with reserved or zero bits get their own cycles.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
    typedef enum logic {
        PEND_IDLE = 1'b0,
        PEND_SET  = 1'b1
    } pend_state_t;
endpackage

// File: rtl/tmr_irq_flag.sv
module tmr_irq_flag
    import tmr_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic sw_set,
    input  logic sw_clr,
    input  logic en_we,
    input  logic en_d,
    output logic pend,
    output logic en
);
    pend_state_t state_q, state_d;
    logic        en_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PEND_IDLE: if (evt || sw_set) state_d = PEND_SET;
            PEND_SET:  if (sw_clr && !evt) state_d = PEND_IDLE;
            default:   state_d = PEND_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PEND_IDLE;
            en_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (en_we) en_q <= en_d;
        end
    end

    always_comb begin
        pend = (state_q == PEND_SET);
        en   = en_q;
    end

    p_evt_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> pend);
    p_evt_beats_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && sw_clr) |=> pend);
    p_zero_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !sw_clr) |=> pend);
    p_clr_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_clr && !evt && !sw_set) |=> !pend);
endmodule

// File: rtl/tmr_irq_regbus.sv
module tmr_irq_regbus #(
    parameter int NUM_SRC   = 4,
    parameter int ADDR_W    = 2,
    parameter int CTRL_ADDR = 0,
    parameter int CLR_ADDR  = 1,
    localparam int DATA_W   = 2 * NUM_SRC
) (
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic [NUM_SRC-1:0] pend_vec,
    input  logic [NUM_SRC-1:0] en_vec,
    output logic [NUM_SRC-1:0] set_vec,
    output logic [NUM_SRC-1:0] clr_vec,
    output logic               en_we,
    output logic [NUM_SRC-1:0] en_d,
    output logic [DATA_W-1:0]  bus_rdata
);
    logic hit_ctrl, hit_clr;

    always_comb begin
        hit_ctrl  = (bus_addr == ADDR_W'(CTRL_ADDR));
        hit_clr   = (bus_addr == ADDR_W'(CLR_ADDR));
        en_we     = bus_we && hit_ctrl;
        en_d      = bus_wdata[DATA_W-1:NUM_SRC];
        set_vec   = (bus_we && hit_ctrl) ? bus_wdata[NUM_SRC-1:0] : '0;
        clr_vec   = (bus_we && hit_clr)  ? bus_wdata[NUM_SRC-1:0] : '0;
        bus_rdata = hit_ctrl ? {en_vec, pend_vec} : '0;
    end

    always_comb begin
        p_set_clr_excl_r6: assert ((set_vec & clr_vec) == '0);
    end
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl #(
    parameter int NUM_SRC   = 4,
    parameter int ADDR_W    = 2,
    parameter int CTRL_ADDR = 0,
    parameter int CLR_ADDR  = 1,
    localparam int DATA_W   = 2 * NUM_SRC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_o
);
    logic [NUM_SRC-1:0] pend_vec, en_vec, set_vec, clr_vec, en_d;
    logic               en_we;
    logic               irq_q;

    tmr_irq_regbus #(
        .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W),
        .CTRL_ADDR(CTRL_ADDR), .CLR_ADDR(CLR_ADDR)
    ) u_bus (
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .pend_vec(pend_vec), .en_vec(en_vec),
        .set_vec(set_vec), .clr_vec(clr_vec),
        .en_we(en_we), .en_d(en_d), .bus_rdata(bus_rdata)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        tmr_irq_flag u_flag (
            .clk(clk), .rst_n(rst_n),
            .evt(evt_i[g]), .sw_set(set_vec[g]), .sw_clr(clr_vec[g]),
            .en_we(en_we), .en_d(en_d[g]),
            .pend(pend_vec[g]), .en(en_vec[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(pend_vec & en_vec);
    end

    assign irq_o = irq_q;

    p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pend_vec & en_vec)) |=> irq_o);
    p_no_irq_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(pend_vec & en_vec)) |=> !irq_o);
    p_read_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_we && evt_i == '0) |=> $stable(pend_vec) && $stable(en_vec));
endmodule

// File: tb/tmr_irq_ctrl_test.sv
module tmr_irq_ctrl_test;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] evt_i = '0;
    logic [1:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_o;

    int checks = 0;
    int failures = 0;
    bit [3:0] m_pend = '0;
    bit [3:0] m_en = '0;
    bit       m_irq = 1'b0;

    tmr_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic compare(input string tag);
        bit [7:0] exp_rd;
        exp_rd = (bus_addr == 2'd0) ? {m_en, m_pend} : 8'h00;
        checks++;
        if (bus_rdata !== exp_rd) begin
            failures++;
            $display("FAIL %s rdata actual=%h expected=%h", tag, bus_rdata, exp_rd);
        end
        checks++;
        if (irq_o !== m_irq) begin
            failures++;
            $display("FAIL %s irq actual=%b expected=%b", tag, irq_o, m_irq);
        end
    endtask

    task automatic step(input bit [3:0] ev, input bit we, input bit [1:0] ad,
                        input bit [7:0] wd, input bit [1:0] rd_ad, input string tag);
        bit [3:0] setv, clrv;
        @(negedge clk);
        evt_i = ev; bus_we = we; bus_addr = ad; bus_wdata = wd;
        setv = (we && ad == 2'd0) ? wd[3:0] : 4'h0;
        clrv = (we && ad == 2'd1) ? wd[3:0] : 4'h0;
        @(posedge clk);
        m_irq  = |(m_pend & m_en);
        m_pend = ev | setv | (m_pend & ~clrv);
        if (we && ad == 2'd0) m_en = wd[7:4];
        #1;
        evt_i = '0; bus_we = 1'b0; bus_addr = rd_ad;
        #1;
        compare(tag);
    endtask

    initial begin
        #(CLK_P * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 compare("R2 reset");
        rst_n = 1'b1;
        step(4'h0, 0, 2'd0, 8'h00, 2'd0, "R2 idle after reset");
        step(4'h1, 0, 2'd0, 8'h00, 2'd0, "R3 R7 event A disabled");
        step(4'h0, 0, 2'd0, 8'h00, 2'd0, "R7 no irq while disabled");
        step(4'h0, 1, 2'd0, 8'h10, 2'd0, "R4 R5 enable A, zero pend ignored");
        step(4'h0, 0, 2'd0, 8'h00, 2'd0, "R8 irq one cycle later");
        step(4'h0, 0, 2'd0, 8'h00, 2'd1, "R10 clear reg reads zero");
        step(4'h0, 0, 2'd0, 8'h00, 2'd0, "R10 control read no side effect");
        step(4'h0, 1, 2'd1, 8'hF0, 2'd0, "R6 reserved clear bits ignored");
        step(4'h0, 1, 2'd1, 8'h01, 2'd0, "R6 clear A");
        step(4'h0, 0, 2'd0, 8'h00, 2'd0, "R8 irq drops");
        step(4'h0, 1, 2'd0, 8'h24, 2'd0, "R1 R4 R5 set C enable B");
        step(4'h0, 0, 2'd0, 8'h00, 2'd0, "R7 C pending not enabled");
        step(4'h2, 1, 2'd1, 8'h02, 2'd0, "R9 event B beats clear B");
        step(4'h0, 0, 2'd0, 8'h00, 2'd0, "R9 irq from B");
        step(4'h0, 1, 2'd1, 8'h02, 2'd0, "R6 clear B");
        step(4'h0, 0, 2'd0, 8'h00, 2'd0, "R8 irq low after clear");
        step(4'hA, 0, 2'd0, 8'h00, 2'd0, "R3 events B D");
        step(4'h0, 1, 2'd0, 8'h80, 2'd0, "R5 enable only D");
        step(4'h0, 0, 2'd0, 8'h00, 2'd0, "R8 irq from D");
        step(4'h0, 1, 2'd1, 8'h05, 2'd0, "R6 clear A C leaves B D");
        step(4'h0, 1, 2'd0, 8'h00, 2'd0, "R4 R5 all-zero write");
        step(4'h0, 0, 2'd0, 8'h00, 2'd0, "R7 pend kept irq off");
        step(4'h0, 1, 2'd1, 8'hFF, 2'd0, "R6 clear all");
        step(4'h0, 1, 2'd0, 8'hFF, 2'd0, "R1 R4 set all enable all");
        step(4'h0, 0, 2'd1, 8'h00, 2'd0, "R8 irq all");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule